// File: doc/BRIEF.md
# Flash Write-Status Read Generator

This block sits on the memory side of a byte-wide parallel flash model and forms the byte returned to the host on every read. While an internal program or erase runs, the read path stops returning array contents. Instead it encodes progress in two data bits. Bit 7 is a polling bit: a program returns the inverse of the byte being written, and an erase returns 0. Bit 6 is a toggle bit that changes level on each new read access.

When the internal operation ends, the array data does not become valid on all bits at the same moment. For a configurable number of clock cycles after busy drops, only bit 7 carries the true array value, and the other bits read as 0. After that window, reads pass the array byte through unchanged. The command decoder that raises the busy flag, the array timing and the pad drivers are separate blocks.

Top module: `wsr_status_gen`

## Requirements
- R1: While busy is low and no settle window is open, the output equals the array byte on every bit.
- R2: While busy is high with the operation type set to program, output bit 7 equals the inverse of bit 7 of the program byte.
- R3: While busy is high with the operation type set to erase, output bit 7 is 0. Once the erase ends, bit 7 follows the array, which reads 1 after an erase.
- R4: While busy is high, output bit 6 is 1 on the first read, and it inverts after each rising edge of the read strobe. A strobe held high, or a strobe held low, leaves it unchanged.
- R5: While busy is high, output bits 5 down to 0 are 0.
- R6: The settle window opens in the first cycle in which busy is low after being high, and it lasts SETTLE_CYCLES cycles. During the window, bit 7 equals array bit 7 and bits 6 to 0 are 0.
- R7: When the settle window ends, the toggle bit stops, and the next busy period starts again at 1.
- R8: After reset, the toggle bit is armed at 1, no settle window is open and reads pass through.
- R9: If busy rises while a settle window is open, the window closes at once and the status encoding applies from that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opBusy | input | 1 | Internal program or erase in progress |
| opErase | input | 1 | 1 = erase, 0 = program |
| progByte | input | DATA_W | Latched byte being programmed |
| arrayByte | input | DATA_W | Array read data |
| readStrobe | input | 1 | Read access strobe; rising edge marks a new read |
| readByte | output | DATA_W | Value returned on the data bus |

## Verification
The bench targets the first read at the very cycle busy rises. A design that armed the toggle late would return 0 there. It also holds the read strobe high across several cycles, where a level-sensitive toggle would flip on every clock. The cycle in which busy falls is checked closely: a settle counter that loads one cycle late lets the full array byte leak through early, and one that loads a cycle early truncates the window. The bench also re-asserts busy in mid-window and resets in mid-operation, so that a stale counter or a stale toggle level shows up as a wrong bit 6 or 7.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  typedef struct packed {
    logic busy;
    logic settling;
    logic erase;
    logic togBit;
  } statusCtl_t;
endpackage

// File: rtl/wsr_status_ctrl.sv
module wsr_status_ctrl
  import wsr_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opBusy,
  input  logic       opErase,
  input  logic       readStrobe,
  output statusCtl_t ctl
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES - 1);

  logic             busyQ;
  logic             strobeQ;
  logic             togQ;
  logic [CNT_W-1:0] settleCnt;
  logic             rdRise;
  logic             busyFall;

  assign rdRise   = readStrobe & ~strobeQ;
  assign busyFall = busyQ & ~opBusy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ   <= 1'b0;
      strobeQ <= 1'b0;
    end else begin
      busyQ   <= opBusy;
      strobeQ <= readStrobe;
    end
  end

  // toggle: armed at 1 whenever idle, flips after each new read while busy
  always_ff @(posedge clk) begin
    if (!rst_n)       togQ <= 1'b1;
    else if (!opBusy) togQ <= 1'b1;
    else if (rdRise)  togQ <= ~togQ;
  end

  // settle window counter; the fall cycle itself is the first window cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                settleCnt <= '0;
    else if (opBusy)           settleCnt <= '0;
    else if (busyFall)         settleCnt <= LOAD_VAL;
    else if (settleCnt != '0)  settleCnt <= settleCnt - 1'b1;
  end

  always_comb begin
    ctl.busy     = opBusy;
    ctl.erase    = opErase;
    ctl.togBit   = togQ;
    ctl.settling = !opBusy && (busyFall || (settleCnt != '0));
  end

  AST_TOG_IDLE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    !opBusy |=> togQ); // R7
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (opBusy && rdRise) |=> (togQ != $past(togQ))); // R4
  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (opBusy && !rdRise) |=> (!opBusy || $stable(togQ))); // R4
  AST_SETTLE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && !opBusy) |-> ctl.settling); // R6
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    settleCnt <= LOAD_VAL); // R6
  AST_BUSY_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    opBusy |=> (!opBusy || settleCnt == '0)); // R9
endmodule

// File: rtl/wsr_status_dp.sv
module wsr_status_dp
  import wsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  statusCtl_t        ctl,
  input  logic [DATA_W-1:0] progByte,
  input  logic [DATA_W-1:0] arrayByte,
  output logic [DATA_W-1:0] readByte
);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  always_comb begin
    readByte = arrayByte;
    if (ctl.busy) begin
      readByte           = '0;
      readByte[POLL_BIT] = ctl.erase ? 1'b0 : ~progByte[POLL_BIT];
      readByte[TOG_BIT]  = ctl.togBit;
    end else if (ctl.settling) begin
      readByte           = '0;
      readByte[POLL_BIT] = arrayByte[POLL_BIT];
    end
  end

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.busy && !ctl.erase) |-> (readByte[POLL_BIT] != progByte[POLL_BIT])); // R2
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.busy && ctl.erase) |-> !readByte[POLL_BIT]); // R3
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.busy |-> (readByte[TOG_BIT-1:0] == '0)); // R5
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.busy && !ctl.settling) |-> (readByte == arrayByte)); // R1
endmodule

// File: rtl/wsr_status_gen.sv
module wsr_status_gen
  import wsr_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opBusy,
  input  logic              opErase,
  input  logic [DATA_W-1:0] progByte,
  input  logic [DATA_W-1:0] arrayByte,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] readByte
);
  statusCtl_t ctl;

  wsr_status_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .opBusy(opBusy), .opErase(opErase),
    .readStrobe(readStrobe), .ctl(ctl)
  );

  wsr_status_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .progByte(progByte),
    .arrayByte(arrayByte), .readByte(readByte)
  );
endmodule

// File: tb/wsr_status_gen_tb.sv
module wsr_status_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opBusy = 1'b0, opErase = 1'b0, readStrobe = 1'b0;
  logic [7:0] progByte = '0, arrayByte = '0;
  logic [7:0] readByte;

  int tests = 0, fails = 0;

  // behavioural reference state
  int mTog = 1, mLeft = 0;
  bit mPrevBusy = 0, mPrevRd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsr_status_gen #(.DATA_W(8), .SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .opBusy(opBusy), .opErase(opErase),
    .progByte(progByte), .arrayByte(arrayByte), .readStrobe(readStrobe),
    .readByte(readByte)
  );

  task automatic check(input logic [7:0] exp, input string tag);
    tests++;
    if (readByte !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, readByte, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare shortly after, advance model at posedge
  task automatic step(input bit b, input bit e, input logic [7:0] pd,
                      input logic [7:0] ad, input bit rd);
    logic [7:0] exp;
    string tag;
    @(negedge clk);
    opBusy = b; opErase = e; progByte = pd; arrayByte = ad; readStrobe = rd;
    #1;
    if (b) begin
      exp = {e ? 1'b0 : ~pd[7], mTog[0], 6'b0};
      tag = e ? "R3 erase poll/R4 toggle/R5 low bits" : "R2 program poll/R4 toggle/R5 low bits";
    end else if ((mPrevBusy && !b) || mLeft > 0) begin
      exp = {ad[7], 7'b0};
      tag = "R6 settle window";
    end else begin
      exp = ad;
      tag = "R1 passthrough";
    end
    check(exp, tag);
    @(posedge clk);
    if (!b)                   mTog = 1;
    else if (rd && !mPrevRd)  mTog = 1 - mTog;
    if (b)                    mLeft = 0;
    else if (mPrevBusy)       mLeft = SETTLE - 1;
    else if (mLeft > 0)       mLeft--;
    mPrevBusy = b;
    mPrevRd   = rd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    mTog = 1; mLeft = 0; mPrevBusy = 0; mPrevRd = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R8: reset state passes array data through
    step(0, 0, 8'h00, 8'h5A, 0);
    step(0, 0, 8'h00, 8'hA5, 1);
    step(0, 0, 8'h00, 8'h00, 0);

    // program of 0x80: read right at busy rise must see toggle 1 (R4)
    step(1, 0, 8'h80, 8'h11, 1);
    step(1, 0, 8'h80, 8'h22, 1);   // held strobe: no flip (R4)
    step(1, 0, 8'h80, 8'h33, 1);
    step(1, 0, 8'h80, 8'h44, 0);
    for (int i = 0; i < 6; i++) step(1, 0, 8'h80, 8'h44, i[0]);
    // completion: settle window then passthrough (R6, R7)
    for (int i = 0; i < SETTLE + 3; i++) step(0, 0, 8'h80, 8'hFE, 0);

    // program of 0x3C (bit 7 clear -> poll 1), R2
    for (int i = 0; i < 8; i++) step(1, 0, 8'h3C, 8'hC3, i[0]);
    for (int i = 0; i < SETTLE + 2; i++) step(0, 0, 8'h3C, 8'h3C, 0);

    // erase: bit 7 low while busy, array FF afterwards reads 1 (R3)
    for (int i = 0; i < 10; i++) step(1, 1, 8'h00, 8'h00, (i % 3) == 0);
    for (int i = 0; i < SETTLE + 2; i++) step(0, 1, 8'h00, 8'hFF, i[0]);

    // R9: busy re-asserts in the middle of the settle window
    for (int i = 0; i < 4; i++) step(1, 0, 8'h01, 8'h77, i[0]);
    for (int i = 0; i < 3; i++) step(0, 0, 8'h01, 8'h77, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 8'h01, 8'h77, i[1]);
    for (int i = 0; i < SETTLE + 2; i++) step(0, 1, 8'h01, 8'hEE, 0);

    // R8: reset while busy, toggle re-armed and no settle after it
    for (int i = 0; i < 3; i++) step(1, 0, 8'h00, 8'h90, i[0]);
    opBusy = 1'b0;
    do_reset();
    step(0, 0, 8'h00, 8'h6B, 0);
    step(1, 0, 8'h00, 8'h6B, 1);
    step(1, 0, 8'h00, 8'h6B, 0);
    step(1, 0, 8'h00, 8'h6B, 1);
    for (int i = 0; i < SETTLE + 2; i++) step(0, 0, 8'h00, 8'hD2, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule